// File: doc/BRIEF.md
# SPI Register Configuration Sequencer

This block is an SPI master that plays a short, fixed configuration script into a register-based peripheral. Every transfer is a 16-bit word: a direction flag at the top, then a 4-bit register address, then an 11-bit data field. The script targets one protected control register. Its upper three data bits form a lock field. The script opens the register, writes the wanted bits, closes the register again, and then reads the same address back. The block compares the returned data with the value the register should now hold.

The serial clock is derived from the system clock by a parameterised divider, and idles low while chip select is high. Outgoing bits change on the SCK rising edge so that the peripheral can take them on the falling edge. A slave with a long output delay can make the read data arrive one bit late. For that case a run-time input moves the MISO capture point from the falling edge to half a period later, where the next rising edge falls.

The block reports three things: a one-cycle done pulse, a sticky mismatch flag and the most recent received word. A start pulse restarts the script from its first entry at any time.

Top module: `spi_cfg_seq`

## Requirements
- R1: Frame layout on MOSI, most significant bit first. Bit 15 is the direction flag, with 1 for read and 0 for write. Bits 14:11 carry the address and bits 10:0 the data. A read frame carries all zeros in bits 10:0.
- R2: After start the block sends exactly four frames to address REG_ADDR, in this order:
  - an open frame: lock field (data bits 10:8) = 3'b011, bits 7:0 = 0;
  - a write frame: lock field 3'b011, bits 7:0 = WANT_BITS;
  - a close frame: lock field 3'b110, bits 7:0 = WANT_BITS when LOCK_CARRIES_DATA = 1, else 0;
  - a read frame.
  With the defaults the four frames are 16'h1B00, 16'h1BFC, 16'h1EFC and 16'h9800.
- R3: Inside a frame, SCK has a period of CLK_DIV system clocks, with CLK_DIV/2 cycles high. SCK is low whenever csN is high.
- R4: While csN is low, MOSI changes only in the cycle in which SCK rises.
- R5: Chip select timing:
  - csN falls at least CS_SETUP system clocks before the first SCK rising edge of a frame;
  - csN rises half an SCK period after the 16th falling edge;
  - between frames, csN stays high for at least IDLE_GAP system clocks.
- R6: MISO capture point:
  - with capLate = 0, MISO is sampled at each SCK falling edge;
  - with capLate = 1, MISO is sampled CLK_DIV/2 system clocks after each falling edge, which is the position of the next rising edge.
- R7: rxWord holds the 16 bits captured in the last completed frame, first captured bit in bit 15. It is cleared to 0 by start.
- R8: Mismatch flag:
  - mismatch is set when bits 10:0 captured in the read frame differ from the close frame's data field;
  - once set, it stays set until the next start, which clears it.
- R9: done is a single-cycle pulse. It is raised once per script, after the idle gap that follows the read frame.
- R10: Restart:
  - a start pulse in any state forces csN high and SCK low in the next cycle;
  - after an idle gap, the script begins again from the open frame;
  - any partly sent frame is abandoned.
- R11: Reset state: csN = 1, SCK = 0, MOSI = 0, done = 0, mismatch = 0, rxWord = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: (re)start the script from the first entry |
| capLate | input | 1 | 0 = capture MISO at SCK fall, 1 = capture half a period later |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock, idles low |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the peripheral |
| done | output | 1 | One-cycle pulse at the end of the script |
| mismatch | output | 1 | Sticky read-back compare failure |
| rxWord | output | 16 | Last received frame |

## Verification
The bench runs the script against a behavioural peripheral that honours the open/close rule on its lock field. The peripheral's output delay is swept across values below and above half an SCK period, with both capture settings.

A short delay shows that both capture points return the true word. A long delay with falling-edge capture must yield the word shifted right by one bit and a raised mismatch flag, while late capture recovers the true word. Running a correct script after a failing one shows that start clears the sticky flag. A start issued in the middle of the script shows that the aborted frame is dropped and that a full four-frame script follows.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 11;
  localparam int WANT_W  = 8;
  localparam int SCRIPT_LEN = 4;
  localparam int IDX_W   = 3;

  localparam logic [2:0] LOCK_OPEN = 3'b011;
  localparam logic [2:0] LOCK_SHUT = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SETUP,
    ST_HIGH,
    ST_LOW
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rise;      // SCK rises this cycle: present next MOSI bit
    logic firstBit;  // first rise of a frame: load frame word
    logic sample;    // capture MISO
    logic frameEnd;  // last capture of the frame is complete
    logic clear;     // restart: clear status
  } dpStrobe_t;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic               isRead;
    logic [DATA_W-1:0]  expData;
  } scriptEntry_t;

  // Script ROM, computed from the block parameters
  function automatic scriptEntry_t buildEntry(input int idx,
                                              input logic [ADDR_W-1:0] addr,
                                              input logic [WANT_W-1:0] want,
                                              input bit lockCarries);
    scriptEntry_t e;
    logic [WANT_W-1:0] shutBits;
    shutBits = lockCarries ? want : '0;
    e = '0;
    case (idx)
      0: e.frame = {1'b0, addr, LOCK_OPEN, {WANT_W{1'b0}}};
      1: e.frame = {1'b0, addr, LOCK_OPEN, want};
      2: e.frame = {1'b0, addr, LOCK_SHUT, shutBits};
      3: begin
        e.frame   = {1'b1, addr, {DATA_W{1'b0}}};
        e.isRead  = 1'b1;
        e.expData = {LOCK_SHUT, shutBits};
      end
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int CLK_DIV  = 12,
  parameter int CS_SETUP = 4,
  parameter int IDLE_GAP = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             capLate,
  output logic [IDX_W-1:0] entryIdx,
  output logic             csN,
  output logic             sck,
  output logic             done,
  output dpStrobe_t        stb
);

  localparam int HALF   = CLK_DIV / 2;
  localparam int TMAX_A = (HALF > CS_SETUP) ? HALF : CS_SETUP;
  localparam int TMAX   = (TMAX_A > IDLE_GAP) ? TMAX_A : IDLE_GAP;
  localparam int TMR_W  = $clog2(TMAX + 1);
  localparam int BIT_W  = $clog2(FRAME_W);

  localparam logic [TMR_W-1:0] HALF_LAST  = TMR_W'(HALF - 1);
  localparam logic [TMR_W-1:0] SETUP_LAST = TMR_W'(CS_SETUP - 1);
  localparam logic [TMR_W-1:0] GAP_LAST   = TMR_W'(IDLE_GAP - 1);
  localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(SCRIPT_LEN - 1);

  seqState_t        state;
  logic [TMR_W-1:0] tmr;
  logic [BIT_W-1:0] bitCnt;
  logic             restartPend;

  logic setupEnd, highEnd, lowEnd, lastBit;

  always_comb begin
    setupEnd = (state == ST_SETUP) && (tmr == SETUP_LAST);
    highEnd  = (state == ST_HIGH)  && (tmr == HALF_LAST);
    lowEnd   = (state == ST_LOW)   && (tmr == HALF_LAST);
    lastBit  = (bitCnt == BIT_LAST);

    stb.clear    = start;
    stb.firstBit = !start && setupEnd;
    stb.rise     = !start && (setupEnd || (lowEnd && !lastBit));
    stb.sample   = !start && (capLate ? lowEnd : highEnd);
    stb.frameEnd = !start && lowEnd && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      tmr         <= '0;
      bitCnt      <= '0;
      entryIdx    <= '0;
      restartPend <= 1'b0;
      csN         <= 1'b1;
      sck         <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state       <= ST_GAP;
        tmr         <= '0;
        entryIdx    <= '0;
        restartPend <= 1'b1;
        csN         <= 1'b1;
        sck         <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: tmr <= '0;
          ST_GAP: begin
            if (tmr == GAP_LAST) begin
              tmr <= '0;
              if (restartPend) begin
                restartPend <= 1'b0;
                csN         <= 1'b0;
                state       <= ST_SETUP;
              end else if (entryIdx == IDX_LAST) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                entryIdx <= entryIdx + 1'b1;
                csN      <= 1'b0;
                state    <= ST_SETUP;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_SETUP: begin
            if (setupEnd) begin
              tmr    <= '0;
              bitCnt <= '0;
              sck    <= 1'b1;
              state  <= ST_HIGH;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_HIGH: begin
            if (highEnd) begin
              tmr   <= '0;
              sck   <= 1'b0;
              state <= ST_LOW;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_LOW: begin
            if (lowEnd) begin
              tmr <= '0;
              if (lastBit) begin
                csN   <= 1'b1;
                state <= ST_GAP;
              end else begin
                bitCnt <= bitCnt + 1'b1;
                sck    <= 1'b1;
                state  <= ST_HIGH;
              end
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_cfg_dp.sv
module spi_cfg_dp
  import spi_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_ADDR  = 4'd3,
  parameter logic [WANT_W-1:0] WANT_BITS = 8'hFC,
  parameter bit LOCK_CARRIES_DATA        = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [IDX_W-1:0]   entryIdx,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rxWord,
  output logic               mismatch
);

  scriptEntry_t       cur;
  logic [FRAME_W-1:0] txShift, txSrc;
  logic [FRAME_W-1:0] rxShift, rxNext;

  always_comb begin
    cur    = buildEntry(int'(entryIdx), REG_ADDR, WANT_BITS, LOCK_CARRIES_DATA);
    txSrc  = stb.firstBit ? cur.frame : txShift;
    rxNext = stb.sample ? {rxShift[FRAME_W-2:0], miso} : rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      mosi     <= 1'b0;
      rxWord   <= '0;
      mismatch <= 1'b0;
    end else if (stb.clear) begin
      rxWord   <= '0;
      mismatch <= 1'b0;
    end else begin
      rxShift <= rxNext;
      if (stb.rise) begin
        mosi    <= txSrc[FRAME_W-1];
        txShift <= {txSrc[FRAME_W-2:0], 1'b0};
      end
      if (stb.frameEnd) begin
        rxWord <= rxNext;
        if (cur.isRead && (rxNext[DATA_W-1:0] != cur.expData))
          mismatch <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
  import spi_cfg_pkg::*;
#(
  parameter int CLK_DIV                  = 12,
  parameter int CS_SETUP                 = 4,
  parameter int IDLE_GAP                 = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 4'd3,
  parameter logic [WANT_W-1:0] WANT_BITS = 8'hFC,
  parameter bit LOCK_CARRIES_DATA        = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        capLate,
  input  logic        miso,
  output logic        sck,
  output logic        csN,
  output logic        mosi,
  output logic        done,
  output logic        mismatch,
  output logic [15:0] rxWord
);

  dpStrobe_t        stb;
  logic [IDX_W-1:0] entryIdx;

  spi_cfg_ctrl #(
    .CLK_DIV (CLK_DIV),
    .CS_SETUP(CS_SETUP),
    .IDLE_GAP(IDLE_GAP)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .capLate (capLate),
    .entryIdx(entryIdx),
    .csN     (csN),
    .sck     (sck),
    .done    (done),
    .stb     (stb)
  );

  spi_cfg_dp #(
    .REG_ADDR         (REG_ADDR),
    .WANT_BITS        (WANT_BITS),
    .LOCK_CARRIES_DATA(LOCK_CARRIES_DATA)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .entryIdx(entryIdx),
    .miso    (miso),
    .mosi    (mosi),
    .rxWord  (rxWord),
    .mismatch(mismatch)
  );

endmodule

// File: rtl/spi_cfg_seq_chk.sv
module spi_cfg_seq_chk #(
  parameter int CLK_DIV  = 12,
  parameter int CS_SETUP = 4,
  parameter int IDLE_GAP = 12
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic sck,
  input logic csN,
  input logic mosi,
  input logic done,
  input logic mismatch
);

  localparam logic [15:0] HALF_CNT  = 16'(CLK_DIV / 2);
  localparam logic [15:0] SETUP_MIN = 16'(CS_SETUP);
  localparam logic [15:0] GAP_MIN   = 16'(IDLE_GAP);

  logic [15:0] gapCnt, setupCnt, hiCnt;
  logic        seenRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      setupCnt <= '0;
      hiCnt    <= '0;
      seenRise <= 1'b0;
    end else begin
      if (csN) gapCnt <= (gapCnt == 16'hFFFF) ? gapCnt : gapCnt + 16'd1;
      else     gapCnt <= '0;
      if (csN) begin
        setupCnt <= '0;
        seenRise <= 1'b0;
      end else begin
        if (sck) seenRise <= 1'b1;
        if (!seenRise && setupCnt != 16'hFFFF) setupCnt <= setupCnt + 16'd1;
      end
      if (sck) hiCnt <= (hiCnt == 16'hFFFF) ? hiCnt : hiCnt + 16'd1;
      else     hiCnt <= '0;
    end
  end

  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  assert_sck_high_time_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sck) && !$past(start)) |-> (hiCnt == HALF_CNT));

  assert_mosi_on_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$stable(mosi)) |-> $rose(sck));

  assert_cs_setup_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sck) && !seenRise) |-> (setupCnt >= SETUP_MIN));

  assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (gapCnt >= GAP_MIN));

  assert_mismatch_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mismatch && !start) |=> mismatch);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_restart_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (csN && !sck));

endmodule

bind spi_cfg_seq spi_cfg_seq_chk #(
  .CLK_DIV (CLK_DIV),
  .CS_SETUP(CS_SETUP),
  .IDLE_GAP(IDLE_GAP)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .sck     (sck),
  .csN     (csN),
  .mosi    (mosi),
  .done    (done),
  .mismatch(mismatch)
);

// File: tb/spi_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module spi_cfg_seq_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic capLate = 1'b0;
  logic miso = 1'b0;
  logic sck, csN, mosi, done, mismatch;
  logic [15:0] rxWord;

  always #5 clk = ~clk;

  spi_cfg_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .capLate(capLate), .miso(miso),
    .sck(sck), .csN(csN), .mosi(mosi), .done(done), .mismatch(mismatch),
    .rxWord(rxWord)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- peripheral model ----------------
  int          mDelay = 10;
  logic [15:0] sIn;
  int          sBits;
  logic [10:0] sReg = 11'h000;
  logic        sLocked = 1'b1;
  logic [15:0] frameLog [0:15];
  int          frameCnt = 0;
  int          slaveK;
  logic        slaveB;

  always @(negedge csN) begin
    sBits = 0;
    sIn   = 16'h0;
  end

  always @(negedge sck) if (!csN) begin
    sIn = {sIn[14:0], mosi};
    sBits++;
  end

  always @(posedge sck) if (!csN) begin
    slaveK = sBits;
    slaveB = (slaveK >= 5 && slaveK < 16) ? sReg[15 - slaveK] : 1'b0;
    #(mDelay);
    miso = slaveB;
  end

  always @(posedge csN) begin
    miso = 1'b0;
    if (sBits == 16) begin
      if (frameCnt < 16) frameLog[frameCnt] = sIn;
      frameCnt++;
      if (!sIn[15] && sIn[14:11] == 4'd3) begin
        if (sLocked) begin
          if (sIn[10:8] == 3'b011) sLocked = 1'b0;
        end else begin
          sReg = sIn[10:0];
          if (sIn[10:8] == 3'b110) sLocked = 1'b1;
        end
      end
    end
    sBits = 0;
  end

  // ---------------- timing monitors (R3, R5) ----------------
  bit      monEn = 1'b1;
  realtime lastRise, lastFall, csFallT, csRiseT;
  bit      haveRise = 1'b0;
  int      periodErr = 0, highErr = 0, setupErr = 0, gapErr = 0, idleErr = 0;

  always @(negedge csN) begin
    csFallT  = $realtime;
    haveRise = 1'b0;
    if (monEn && ($realtime - csRiseT) < 120.0) gapErr++;
  end
  always @(posedge csN) csRiseT = $realtime;
  always @(posedge sck) begin
    if (monEn) begin
      if (csN) idleErr++;
      if (haveRise && ($realtime - lastRise) != 120.0) periodErr++;
      if (!haveRise && ($realtime - csFallT) < 40.0) setupErr++;
    end
    haveRise = 1'b1;
    lastRise = $realtime;
  end
  always @(negedge sck) begin
    lastFall = $realtime;
    if (monEn && (lastFall - lastRise) != 60.0) highErr++;
  end

  int doneCnt = 0;
  always @(negedge clk) if (done) doneCnt++;

  // expected frames from R2 (addr 3, wanted bits 0xFC, lock carries data)
  function automatic logic [15:0] expFrame(input int i);
    case (i)
      0: return {1'b0, 4'd3, 3'b011, 8'h00};
      1: return {1'b0, 4'd3, 3'b011, 8'hFC};
      2: return {1'b0, 4'd3, 3'b110, 8'hFC};
      default: return {1'b1, 4'd3, 11'h000};
    endcase
  endfunction

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runScript(input int dly, input bit late);
    logic [15:0] trueWord, expWord;
    bit          shifted;
    mDelay  = dly;
    capLate = late;
    @(negedge clk);
    frameCnt = 0;
    doneCnt  = 0;
    pulseStart();
    check(rxWord == 16'h0 && mismatch == 1'b0, "R7 R8 cleared by start", {15'h0, mismatch, rxWord}, 32'h0);
    while (doneCnt == 0) @(negedge clk);
    trueWord = {5'b0, 3'b110, 8'hFC};
    shifted  = !late && (dly > 60);
    expWord  = shifted ? {1'b0, trueWord[15:1]} : trueWord;
    check(rxWord == expWord, $sformatf("R6 R7 rxWord dly=%0d late=%0d", dly, late), rxWord, expWord);
    check(mismatch == shifted, $sformatf("R8 mismatch dly=%0d late=%0d", dly, late), mismatch, shifted);
    check(frameCnt == 4, "R2 frame count", frameCnt, 4);
    for (int i = 0; i < 4; i++)
      check(frameLog[i] == expFrame(i), $sformatf("R1 R2 frame %0d", i), frameLog[i], expFrame(i));
    repeat (30) @(negedge clk);
    check(doneCnt == 1, "R9 single done pulse", doneCnt, 1);
    check(mismatch == shifted, "R8 mismatch held after done", mismatch, shifted);
    check(csN == 1'b1 && sck == 1'b0, "R3 idle after script", {csN, sck}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0 && mosi == 1'b0 && done == 1'b0 &&
          mismatch == 1'b0 && rxWord == 16'h0, "R11 reset state",
          {csN, sck, mosi, done, mismatch, rxWord}, 21'h100000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0, "R11 idle before start", {csN, sck}, 2'b10);

    for (int late = 0; late < 2; late++) begin
      runScript(10, late[0]);
      runScript(40, late[0]);
      runScript(80, late[0]);
      runScript(110, late[0]);
    end

    // restart in the middle of the script (R10)
    mDelay  = 10;
    capLate = 1'b0;
    pulseStart();
    repeat (300) @(negedge clk);
    check(csN == 1'b0, "R10 mid-frame before restart", csN, 0);
    monEn = 1'b0;
    @(negedge clk);
    frameCnt = 0;
    doneCnt  = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(csN == 1'b1 && sck == 1'b0, "R10 abort drives idle", {csN, sck}, 2'b10);
    repeat (20) @(negedge clk);
    monEn = 1'b1;
    while (doneCnt == 0) @(negedge clk);
    check(frameCnt == 4, "R10 full script after restart", frameCnt, 4);
    check(frameLog[0] == expFrame(0), "R10 restart begins with open frame", frameLog[0], expFrame(0));
    check(rxWord == 16'h06FC && mismatch == 1'b0, "R10 restart read-back", rxWord, 16'h06FC);

    check(periodErr == 0, "R3 SCK period", periodErr, 0);
    check(highErr == 0, "R3 SCK high time", highErr, 0);
    check(idleErr == 0, "R3 SCK low while csN high", idleErr, 0);
    check(setupErr == 0, "R5 csN setup", setupErr, 0);
    check(gapErr == 0, "R5 csN idle gap", gapErr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule